// File: doc/BRIEF.md
# Virtual Interrupt Recognition and Delivery Engine

This block models the pending-interrupt path of a virtualized interrupt controller. It keeps two 256-entry vector sets: the requested set and the in-service set. It also keeps three byte registers: the requesting vector, the servicing vector and the virtual processor priority. Recognition of a pending virtual interrupt is re-evaluated only when one of five trigger pulses arrives. On each evaluation the block compares priority classes, which are the upper four bits of the requesting vector and of the priority byte.

Once an interrupt is recognized, the block waits for an instruction-boundary strobe with every gating condition open. It then delivers the interrupt. Delivery moves the vector from the requested set to the in-service set, raises the priority to the vector's class and pulses the delivered vector on its output. In the following cycle the block rescans the requested set for the new highest entry.

The control is a three-state machine:
- **IDLE**: nothing is recognized.
- **PENDING**: an interrupt is recognized.
- **RESCAN**: this is the single cycle after a delivery, in which the requesting vector reloads from the priority encoder.

The transitions are:
- **IDLE → PENDING**: an evaluation hit.
- **PENDING → RESCAN**: a delivery.
- **PENDING → IDLE**: the window-exit control is set, or a trigger evaluates to a miss.
- **RESCAN → PENDING**: an evaluation hit in the rescan cycle.
- **RESCAN → IDLE**: otherwise.

Load ports set request bits and write the requesting vector and the priority directly. A trigger in the same cycle as such a write uses the written values.

Top module: `vint_engine`

## Requirements
- R1: Synchronous active-high reset clears both vector sets, the requesting vector, the servicing vector, the priority, recognition and every output pulse to 0.
- R2: When any trigger input (`trig_entry`, `trig_tpr`, `trig_eoi`, `trig_selfipi`, `trig_posted`) is high and `win_exit` is 0, `recog` is 1 in the next cycle exactly when bits [7:4] of the requesting vector are strictly greater than bits [7:4] of the priority. An equal or lower class gives 0.
- R3: Writes to the requesting vector or the priority with no trigger pulse leave `recog` unchanged.
- R4: A trigger in the same cycle as a direct write of the requesting vector or the priority evaluates with the written values.
- R5: A delivery takes place only while recognized, on a `boundary` cycle with `if_flag`=1, `blk_sti`=0, `blk_ss`=0, `win_exit`=0 and `hi_evt`=0. Otherwise `dlv_valid` stays 0 and recognition is kept.
- R6: One cycle after a delivering strobe, the following hold: `dlv_valid` is 1 for one cycle; `dlv_vec` equals the old requesting vector V; in-service bit V is set; request bit V is cleared; `svi` equals V; and `vppr` equals V with bits [3:0] cleared.
- R7: Two cycles after the delivering strobe, the requesting vector equals the index of the highest set request bit, or 0 when none is set.
- R8: Recognition is 0 in the cycle in which `dlv_valid` is 1.
- R9: While `win_exit` is 1, recognition is dropped in the next cycle, a trigger never recognizes, and no delivery occurs.
- R10: `act_state` encodes 0 running, 1 halted, 2 monitor-wait, 3 shutdown and 4 waiting for startup IPI. `wake` pulses with a delivery made in states 1 or 2. No delivery and no wake occur in states 3 or 4.
- R11: `ext_deferred` pulses together with `dlv_valid` when `ext_req` was high in the delivering cycle.
- R12: `hi_evt`=1 suppresses delivery in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set_en | input | 1 | Set one request bit |
| req_set_vec | input | 8 | Index of the request bit to set |
| wr_rvi_en | input | 1 | Direct write of the requesting vector |
| wr_rvi_val | input | 8 | Requesting vector write value |
| wr_ppr_en | input | 1 | Direct write of the priority |
| wr_ppr_val | input | 8 | Priority write value |
| trig_entry | input | 1 | Evaluation trigger: entry event |
| trig_tpr | input | 1 | Evaluation trigger: priority-register virtualization |
| trig_eoi | input | 1 | Evaluation trigger: end-of-interrupt virtualization |
| trig_selfipi | input | 1 | Evaluation trigger: self-IPI virtualization |
| trig_posted | input | 1 | Evaluation trigger: posted-interrupt processing |
| win_exit | input | 1 | Interrupt-window exiting control |
| if_flag | input | 1 | Interrupt-enable flag |
| blk_sti | input | 1 | Blocking after interrupt-enable instruction |
| blk_ss | input | 1 | Blocking after stack-segment load |
| hi_evt | input | 1 | NMI or higher-priority event present |
| ext_req | input | 1 | External interrupt request |
| act_state | input | 3 | Activity state encoding (see R10) |
| boundary | input | 1 | Instruction-boundary strobe |
| dlv_valid | output | 1 | Delivery pulse |
| dlv_vec | output | 8 | Delivered vector |
| wake | output | 1 | Wake from halt or monitor-wait |
| ext_deferred | output | 1 | External request deferred by a delivery |
| recog | output | 1 | Pending virtual interrupt recognized |
| rvi | output | 8 | Requesting vector |
| svi | output | 8 | Servicing vector |
| vppr | output | 8 | Virtual processor priority |
| irr | output | 256 | Requested vector set |
| isr | output | 256 | In-service vector set |

## Verification
A wrong state-machine state shows up on `recog` in the cycle after the trigger or gating event that caused it. It also shows up as a missing or extra `dlv_valid` at the next boundary strobe. A wrong delivery update shows on `svi`, `vppr` and the two vector sets one cycle after the strobe. A wrong priority-encoder result shows on `rvi` one cycle later, and it steers which vector every later delivery carries. The scoreboard therefore catches an encoder fault twice: once at `rvi`, and again as a mismatched vector on the following delivery.

// File: rtl/vint_pkg.sv
package vint_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_RESCAN = 2'd2
    } vint_state_e;

    localparam logic [2:0] ACT_RUN   = 3'd0;
    localparam logic [2:0] ACT_HALT  = 3'd1;
    localparam logic [2:0] ACT_MWAIT = 3'd2;
    localparam logic [2:0] ACT_SHUT  = 3'd3;
    localparam logic [2:0] ACT_SIPI  = 3'd4;

    localparam int N_TRIG = 5;

endpackage

// File: rtl/vint_prio_enc.sv
module vint_prio_enc #(
    parameter int N = 256,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] bits,
    output logic [W-1:0] idx,
    output logic         any
);
    // Ascending scan: the last set bit seen is the highest one.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                idx = W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vint_eval.sv
module vint_eval
    import vint_pkg::*;
#(
    parameter int VW    = 8,
    parameter int CLS_W = 4
) (
    input  logic [N_TRIG-1:0] trig,
    input  logic              win_exit,
    input  logic [VW-1:0]     rvi_v,
    input  logic [VW-1:0]     ppr_v,
    output logic              fire,
    output logic              hit
);
    logic [CLS_W-1:0] rvi_cls;
    logic [CLS_W-1:0] ppr_cls;

    assign rvi_cls = rvi_v[VW-1 -: CLS_W];
    assign ppr_cls = ppr_v[VW-1 -: CLS_W];
    assign fire    = |trig;
    assign hit     = fire && !win_exit && (rvi_cls > ppr_cls);
endmodule

// File: rtl/vint_gate.sv
module vint_gate
    import vint_pkg::*;
(
    input  logic       boundary,
    input  logic       if_flag,
    input  logic       blk_sti,
    input  logic       blk_ss,
    input  logic       win_exit,
    input  logic       hi_evt,
    input  logic [2:0] act_state,
    output logic       open,
    output logic       wake_ok
);
    logic asleep_hard;

    assign asleep_hard = (act_state == ACT_SHUT) || (act_state == ACT_SIPI);
    assign open        = boundary && if_flag && !blk_sti && !blk_ss &&
                         !win_exit && !hi_evt && !asleep_hard;
    assign wake_ok     = (act_state == ACT_HALT) || (act_state == ACT_MWAIT);
endmodule

// File: rtl/vint_engine.sv
module vint_engine
    import vint_pkg::*;
#(
    parameter int NVEC  = 256,
    parameter int CLS_W = 4,
    localparam int VW    = $clog2(NVEC),
    localparam int SUB_W = VW - CLS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_set_en,
    input  logic [VW-1:0]   req_set_vec,
    input  logic            wr_rvi_en,
    input  logic [VW-1:0]   wr_rvi_val,
    input  logic            wr_ppr_en,
    input  logic [VW-1:0]   wr_ppr_val,
    input  logic            trig_entry,
    input  logic            trig_tpr,
    input  logic            trig_eoi,
    input  logic            trig_selfipi,
    input  logic            trig_posted,
    input  logic            win_exit,
    input  logic            if_flag,
    input  logic            blk_sti,
    input  logic            blk_ss,
    input  logic            hi_evt,
    input  logic            ext_req,
    input  logic [2:0]      act_state,
    input  logic            boundary,
    output logic            dlv_valid,
    output logic [VW-1:0]   dlv_vec,
    output logic            wake,
    output logic            ext_deferred,
    output logic            recog,
    output logic [VW-1:0]   rvi,
    output logic [VW-1:0]   svi,
    output logic [VW-1:0]   vppr,
    output logic [NVEC-1:0] irr,
    output logic [NVEC-1:0] isr
);
    vint_state_e state_q, state_d;

    logic [NVEC-1:0] irr_q, isr_q;
    logic [VW-1:0]   rvi_q, svi_q, ppr_q;
    logic [VW-1:0]   rvi_pre, ppr_pre;
    logic [VW-1:0]   scan_idx;
    logic            scan_any;
    logic [NVEC-1:0] set_mask, hit_mask;
    logic            fire, hit, gate_open, wake_ok, deliver;
    logic [N_TRIG-1:0] trig_vec;

    logic            dlv_valid_q, wake_q, defer_q;
    logic [VW-1:0]   dlv_vec_q;

    assign trig_vec = {trig_posted, trig_selfipi, trig_eoi, trig_tpr, trig_entry};

    // Highest pending request; used in the rescan cycle after a delivery.
    vint_prio_enc #(.N(NVEC)) u_enc (
        .bits (irr_q),
        .idx  (scan_idx),
        .any  (scan_any)
    );

    // Post-write views used by evaluation (direct write wins over rescan).
    always_comb begin
        if (wr_rvi_en)                 rvi_pre = wr_rvi_val;
        else if (state_q == ST_RESCAN) rvi_pre = scan_any ? scan_idx : '0;
        else                           rvi_pre = rvi_q;
        ppr_pre = wr_ppr_en ? wr_ppr_val : ppr_q;
    end

    vint_eval #(.VW(VW), .CLS_W(CLS_W)) u_eval (
        .trig     (trig_vec),
        .win_exit (win_exit),
        .rvi_v    (rvi_pre),
        .ppr_v    (ppr_pre),
        .fire     (fire),
        .hit      (hit)
    );

    vint_gate u_gate (
        .boundary  (boundary),
        .if_flag   (if_flag),
        .blk_sti   (blk_sti),
        .blk_ss    (blk_ss),
        .win_exit  (win_exit),
        .hi_evt    (hi_evt),
        .act_state (act_state),
        .open      (gate_open),
        .wake_ok   (wake_ok)
    );

    assign deliver = (state_q == ST_PEND) && gate_open;

    always_comb begin
        set_mask = '0;
        hit_mask = '0;
        if (req_set_en) set_mask[req_set_vec] = 1'b1;
        if (deliver)    hit_mask[rvi_q]       = 1'b1;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hit) state_d = ST_PEND;
            end
            ST_PEND: begin
                if (deliver)           state_d = ST_RESCAN;
                else if (win_exit)     state_d = ST_IDLE;
                else if (fire && !hit) state_d = ST_IDLE;
            end
            ST_RESCAN: begin
                state_d = hit ? ST_PEND : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Architectural vector state
    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q <= '0;
            isr_q <= '0;
            rvi_q <= '0;
            svi_q <= '0;
            ppr_q <= '0;
        end else begin
            irr_q <= (irr_q | set_mask) & ~hit_mask;
            isr_q <= isr_q | hit_mask;
            rvi_q <= rvi_pre;
            if (deliver) begin
                svi_q <= rvi_q;
                ppr_q <= {rvi_q[VW-1 -: CLS_W], {SUB_W{1'b0}}};
            end else begin
                ppr_q <= ppr_pre;
            end
        end
    end

    // Output pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            dlv_valid_q <= 1'b0;
            dlv_vec_q   <= '0;
            wake_q      <= 1'b0;
            defer_q     <= 1'b0;
        end else begin
            dlv_valid_q <= deliver;
            wake_q      <= deliver && wake_ok;
            defer_q     <= deliver && ext_req;
            if (deliver) dlv_vec_q <= rvi_q;
        end
    end

    assign dlv_valid    = dlv_valid_q;
    assign dlv_vec      = dlv_vec_q;
    assign wake         = wake_q;
    assign ext_deferred = defer_q;
    assign recog        = (state_q == ST_PEND);
    assign rvi          = rvi_q;
    assign svi          = svi_q;
    assign vppr         = ppr_q;
    assign irr          = irr_q;
    assign isr          = isr_q;
endmodule

// File: rtl/vint_engine_chk.sv
module vint_engine_chk #(
    parameter int NVEC  = 256,
    parameter int CLS_W = 4,
    localparam int VW    = $clog2(NVEC),
    localparam int SUB_W = VW - CLS_W
) (
    input logic            clk,
    input logic            rst,
    input logic            boundary,
    input logic            if_flag,
    input logic            blk_sti,
    input logic            blk_ss,
    input logic            win_exit,
    input logic            hi_evt,
    input logic            ext_req,
    input logic            dlv_valid,
    input logic [VW-1:0]   dlv_vec,
    input logic            wake,
    input logic            ext_deferred,
    input logic            recog,
    input logic [VW-1:0]   svi,
    input logic [VW-1:0]   vppr,
    input logic [NVEC-1:0] isr,
    input logic [NVEC-1:0] irr
);
    // R5
    dlv_gated_chk: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> $past(boundary && if_flag && !blk_sti && !blk_ss && !win_exit));

    // R12
    dlv_hi_evt_chk: assert property (@(posedge clk) disable iff (rst)
        hi_evt |=> !dlv_valid);

    // R6
    dlv_update_chk: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> (svi == dlv_vec) && isr[dlv_vec] && !irr[dlv_vec] &&
                      (vppr == {dlv_vec[VW-1 -: CLS_W], {SUB_W{1'b0}}}));

    // R8
    dlv_clears_recog_chk: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> !recog);

    // R9
    win_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        win_exit |=> !recog && !dlv_valid);

    // R10
    wake_with_dlv_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> dlv_valid);

    // R11
    defer_with_dlv_chk: assert property (@(posedge clk) disable iff (rst)
        ext_deferred |-> dlv_valid && $past(ext_req));
endmodule

bind vint_engine vint_engine_chk #(.NVEC(NVEC), .CLS_W(CLS_W)) u_chk (.*);

// File: tb/vint_engine_bench.sv
module vint_engine_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_set_en, wr_rvi_en, wr_ppr_en;
    logic [7:0]   req_set_vec, wr_rvi_val, wr_ppr_val;
    logic         trig_entry, trig_tpr, trig_eoi, trig_selfipi, trig_posted;
    logic         win_exit, if_flag, blk_sti, blk_ss, hi_evt, ext_req, boundary;
    logic [2:0]   act_state;
    logic         dlv_valid, wake, ext_deferred, recog;
    logic [7:0]   dlv_vec, rvi, svi, vppr;
    logic [255:0] irr, isr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [8:0] exp_q[$];

    always #2 clk = ~clk;

    vint_engine u_vint_engine (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_pulses();
        req_set_en = 0; wr_rvi_en = 0; wr_ppr_en = 0;
        trig_entry = 0; trig_tpr = 0; trig_eoi = 0; trig_selfipi = 0; trig_posted = 0;
        boundary = 0; ext_req = 0;
    endtask

    task automatic set_req(logic [7:0] v);
        req_set_en = 1; req_set_vec = v;
        @(negedge clk);
        clear_pulses();
    endtask

    // Driver: strobe a delivery and push the expected result.
    task automatic strobe_deliver(logic [7:0] v, logic w, logic ext);
        exp_q.push_back({w, v});
        boundary = 1; if_flag = 1; ext_req = ext;
        @(negedge clk);
        clear_pulses();
    endtask

    // Monitor: pop and compare on every delivery pulse.
    always @(negedge clk) begin
        if (!rst && dlv_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R5 actual=unexpected delivery %0h expected=none", dlv_vec);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check("R6 dlv_vec", 32'(dlv_vec), 32'(e[7:0]));
                check("R10 wake", 32'(wake), 32'(e[8]));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; clear_pulses();
        req_set_vec = 0; wr_rvi_val = 0; wr_ppr_val = 0;
        win_exit = 0; if_flag = 0; blk_sti = 0; blk_ss = 0; hi_evt = 0;
        act_state = 3'd0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1
        check("R1 rvi", 32'(rvi), 0);
        check("R1 svi", 32'(svi), 0);
        check("R1 vppr", 32'(vppr), 0);
        check("R1 recog", 32'(recog), 0);
        check("R1 dlv_valid", 32'(dlv_valid), 0);
        check("R1 irr", 32'(|irr), 0);
        check("R1 isr", 32'(|isr), 0);

        set_req(8'h31); set_req(8'h85); set_req(8'h52);
        check("R6 irr setup", 32'({irr[8'h31], irr[8'h85], irr[8'h52]}), 32'h7);

        // R3: write with no trigger
        wr_rvi_en = 1; wr_rvi_val = 8'h85;
        @(negedge clk); clear_pulses();
        check("R3 recog untouched", 32'(recog), 0);

        // R2: trigger with class 8 > 0
        trig_tpr = 1;
        @(negedge clk); clear_pulses();
        check("R2 recog hit", 32'(recog), 1);

        // R3: priority write without trigger keeps recognition
        wr_ppr_en = 1; wr_ppr_val = 8'h90;
        @(negedge clk); clear_pulses();
        check("R3 recog kept", 32'(recog), 1);
        wr_ppr_en = 1; wr_ppr_val = 8'h00;
        @(negedge clk); clear_pulses();

        // R5 gating
        boundary = 1; if_flag = 0;
        @(negedge clk); clear_pulses();
        check("R5 if_flag=0", 32'(dlv_valid), 0);
        boundary = 1; if_flag = 1; blk_sti = 1;
        @(negedge clk); clear_pulses(); blk_sti = 0;
        check("R5 sti block", 32'(dlv_valid), 0);
        boundary = 1; blk_ss = 1;
        @(negedge clk); clear_pulses(); blk_ss = 0;
        check("R5 ss block", 32'(dlv_valid), 0);
        boundary = 1; hi_evt = 1;
        @(negedge clk); clear_pulses(); hi_evt = 0;
        check("R12 hi_evt", 32'(dlv_valid), 0);
        boundary = 1; act_state = 3'd3;
        @(negedge clk); clear_pulses();
        check("R10 shutdown dlv", 32'(dlv_valid), 0);
        check("R10 shutdown wake", 32'(wake), 0);
        boundary = 1; act_state = 3'd4;
        @(negedge clk); clear_pulses();
        check("R10 sipi dlv", 32'(dlv_valid), 0);
        check("R5 recog kept", 32'(recog), 1);

        // First delivery, halted, external request deferred
        act_state = 3'd1;
        strobe_deliver(8'h85, 1'b1, 1'b1);
        check("R6 dlv_valid", 32'(dlv_valid), 1);
        check("R11 ext_deferred", 32'(ext_deferred), 1);
        check("R6 svi", 32'(svi), 32'h85);
        check("R6 vppr", 32'(vppr), 32'h80);
        check("R6 isr bit", 32'(isr[8'h85]), 1);
        check("R6 irr bit", 32'(irr[8'h85]), 0);
        check("R8 recog cleared", 32'(recog), 0);
        @(negedge clk);
        check("R7 rescan", 32'(rvi), 32'h52);
        check("R6 pulse width", 32'(dlv_valid), 0);

        // R2: class 5 not above 8
        trig_eoi = 1;
        @(negedge clk); clear_pulses();
        check("R2 lower class", 32'(recog), 0);
        // R2/R4: equal class with same-cycle write
        wr_ppr_en = 1; wr_ppr_val = 8'h5A; trig_eoi = 1;
        @(negedge clk); clear_pulses();
        check("R2 equal class", 32'(recog), 0);
        // R4: same-cycle write then hit
        wr_ppr_en = 1; wr_ppr_val = 8'h40; trig_posted = 1;
        @(negedge clk); clear_pulses();
        check("R4 post-write eval", 32'(recog), 1);

        // R9
        win_exit = 1;
        @(negedge clk);
        check("R9 recog dropped", 32'(recog), 0);
        boundary = 1; if_flag = 1; trig_selfipi = 1;
        @(negedge clk); clear_pulses();
        check("R9 no dlv", 32'(dlv_valid), 0);
        check("R9 no recog", 32'(recog), 0);
        win_exit = 0;

        trig_selfipi = 1;
        @(negedge clk); clear_pulses();
        check("R2 selfipi hit", 32'(recog), 1);
        act_state = 3'd0;
        strobe_deliver(8'h52, 1'b0, 1'b0);
        check("R11 no defer", 32'(ext_deferred), 0);
        check("R6 vppr 2", 32'(vppr), 32'h50);
        @(negedge clk);
        check("R7 rescan 2", 32'(rvi), 32'h31);

        wr_ppr_en = 1; wr_ppr_val = 8'h20; trig_entry = 1;
        @(negedge clk); clear_pulses();
        check("R2 entry hit", 32'(recog), 1);
        act_state = 3'd2;
        strobe_deliver(8'h31, 1'b1, 1'b0);
        check("R6 svi 3", 32'(svi), 32'h31);
        @(negedge clk);
        check("R7 empty", 32'(rvi), 0);
        check("R7 irr empty", 32'(|irr), 0);

        repeat (3) @(negedge clk);
        check("R6 all delivered", 32'(exp_q.size()), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule